// File: doc/BRIEF.md
# Compute-Unit Thread Group Admission and Warp Placement

This block sits between a work distributor and one compute unit. The distributor offers one thread group at a time over a valid/ready request. The request carries the group's id, its warp count, its shared-memory need in 256-byte units, its barrier-slot need and its register blocks per warp. The block takes the group only when every one of the four pools can cover the whole need in that cycle. It then books the group-level shared memory and barriers, together with the warp slots and registers.

After a group is admitted, the block creates its warps, one per cycle. Each warp is placed on one of four sub-partitions, chosen by a rotating pointer that carries over from group to group. The warp is given the lowest free slot there. A warp keeps its slot and registers until the execution side reports first that its threads have finished and then that its issued instructions have drained. Only then are its slot and registers returned. Shared memory and barriers stay booked until the last warp of the group has drained. After that the block sends the distributor a one-cycle completion pulse carrying the group id. A resident group is never evicted, however long it stalls.

Top module: `cu_group_alloc`

## Requirements
- R1: `req_ready` is high only while no warps are being created and the request fits. A request fits when `req_warps` is at least 1, and `req_warps`, `req_smem`, `req_bars` and `req_warps*req_regs` are each no larger than the free warp slots, shared-memory units, barrier slots and register blocks. Otherwise the request is held with `req_ready` low.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. From the next cycle, `alloc_valid` is high for exactly `req_warps` consecutive cycles, one warp per cycle, with `alloc_gid` equal to the accepted id. `req_ready` stays low throughout.
- R3: Each warp goes to the sub-partition at the rotating pointer if that sub-partition has a free slot. Otherwise it goes to the next one in increasing order, modulo 4, that has a free slot. The pointer then moves to the chosen sub-partition plus one (modulo 4) and carries over to later groups. After reset the pointer is 0.
- R4: `alloc_wid` equals sub-partition*8 + slot, where slot is the lowest free slot in that sub-partition. The slot stays taken until the warp is freed.
- R5: A `drain_valid` for a warp is honoured only after a `retire_valid` for the same warp. A drain on a warp that has not retired, or on a free slot, has no effect.
- R6: An honoured drain returns the warp's slot and its `req_regs` register blocks. They count as free from the next cycle on.
- R7: The group's shared memory and barriers are returned only when its last live warp drains. In the next cycle `done_valid` is high for one cycle with `done_gid` equal to the group id.
- R8: After reset, all pools are full, no warp is resident, and `alloc_valid` and `done_valid` are low.
- R9: Resources freed by a drain in a cycle are not counted by that same cycle's admission check. They are counted from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Group request offered |
| req_ready | output | 1 | Group request can be taken this cycle |
| req_gid | input | 3 | Group id |
| req_warps | input | 6 | Warps in the group |
| req_smem | input | 9 | Shared memory in 256-byte units |
| req_bars | input | 5 | Barrier slots |
| req_regs | input | 9 | Register blocks per warp |
| alloc_valid | output | 1 | A warp is placed this cycle |
| alloc_sp | output | 2 | Sub-partition of the placed warp |
| alloc_wid | output | 5 | Warp id of the placed warp |
| alloc_gid | output | 3 | Group of the placed warp |
| retire_valid | input | 1 | A warp's threads have all finished |
| retire_wid | input | 5 | Warp id for retire |
| drain_valid | input | 1 | A retired warp has no instructions left in flight |
| drain_wid | input | 5 | Warp id for drain |
| done_valid | output | 1 | One-cycle group completion pulse |
| done_gid | output | 3 | Completed group id |

## Verification
Two things can happen in the same cycle: a drain that frees a group's last warp, and an admission check for a waiting request that only fits once those resources are back. The bench holds a request that is short by exactly the freed amount and issues the final drain while the request is offered. It expects `req_ready` low in that cycle, the completion pulse and `req_ready` high in the next cycle, and warp placement on the following cycles. A behavioural model running alongside judges every output on every clock. A drain issued in the same cycle as warp placement is covered the same way.

// File: rtl/cga_pkg.sv
package cga_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_EMIT = 1'b1} cga_state_e;
endpackage

// File: rtl/cga_fit.sv
module cga_fit #(
  parameter int WCNT_W = 6,
  parameter int SMEM_W = 9,
  parameter int BAR_W  = 5,
  parameter int REG_W  = 9,
  localparam int NEED_W = WCNT_W + REG_W
) (
  input  logic [WCNT_W-1:0] need_warps,
  input  logic [SMEM_W-1:0] need_smem,
  input  logic [BAR_W-1:0]  need_bars,
  input  logic [REG_W-1:0]  need_regs,
  input  logic [WCNT_W-1:0] free_warps,
  input  logic [SMEM_W-1:0] free_smem,
  input  logic [BAR_W-1:0]  free_bars,
  input  logic [REG_W-1:0]  free_regs,
  output logic [NEED_W-1:0] reg_total,
  output logic              fits
);
  // total register blocks a group asks for
  function automatic logic [NEED_W-1:0] reg_need(input logic [WCNT_W-1:0] w,
                                                 input logic [REG_W-1:0] r);
    return NEED_W'(w) * NEED_W'(r);
  endfunction

  assign reg_total = reg_need(need_warps, need_regs);

  // all four pools must cover the request at once
  assign fits = (need_warps != '0)
             && (need_warps <= free_warps)
             && (need_smem  <= free_smem)
             && (need_bars  <= free_bars)
             && (reg_total  <= NEED_W'(free_regs));
endmodule

// File: rtl/cga_rr_pick.sv
module cga_rr_pick #(
  parameter int NUM_SP = 4,
  parameter int SLOTS  = 8,
  localparam int TOT    = NUM_SP * SLOTS,
  localparam int SP_W   = (NUM_SP > 1) ? $clog2(NUM_SP) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int WID_W  = (TOT > 1) ? $clog2(TOT) : 1
) (
  input  logic [TOT-1:0]  busy,
  input  logic [SP_W-1:0] ptr,
  output logic            pick_ok,
  output logic [SP_W-1:0] pick_sp,
  output logic [WID_W-1:0] pick_wid
);
  logic [NUM_SP-1:0] sp_has_free;
  logic [SLOT_W-1:0] low_slot [NUM_SP];

  // per sub-partition: any free slot, and the lowest one
  for (genvar s = 0; s < NUM_SP; s++) begin : g_sp
    logic              hf;
    logic [SLOT_W-1:0] ls;
    always_comb begin
      hf = 1'b0;
      ls = '0;
      for (int j = SLOTS - 1; j >= 0; j--) begin
        if (!busy[s*SLOTS + j]) begin
          hf = 1'b1;
          ls = SLOT_W'(j);
        end
      end
    end
    assign sp_has_free[s] = hf;
    assign low_slot[s]    = ls;
  end

  // first sub-partition with room, starting at the pointer
  always_comb begin
    pick_ok  = 1'b0;
    pick_sp  = '0;
    pick_wid = '0;
    for (int k = 0; k < NUM_SP; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NUM_SP;
      if (!pick_ok && sp_has_free[idx]) begin
        pick_ok  = 1'b1;
        pick_sp  = SP_W'(idx);
        pick_wid = WID_W'(idx * SLOTS + int'(low_slot[idx]));
      end
    end
  end
endmodule

// File: rtl/cu_group_alloc.sv
module cu_group_alloc
  import cga_pkg::*;
#(
  parameter int NUM_SP       = 4,
  parameter int SLOTS_PER_SP = 8,
  parameter int SMEM_UNITS   = 256,
  parameter int BAR_SLOTS    = 16,
  parameter int REG_BLKS     = 256,
  parameter int GID_W        = 3,
  localparam int TOT_WARPS = NUM_SP * SLOTS_PER_SP,
  localparam int SP_W      = (NUM_SP > 1) ? $clog2(NUM_SP) : 1,
  localparam int WID_W     = (TOT_WARPS > 1) ? $clog2(TOT_WARPS) : 1,
  localparam int WCNT_W    = $clog2(TOT_WARPS + 1),
  localparam int SMEM_W    = $clog2(SMEM_UNITS + 1),
  localparam int BAR_W     = $clog2(BAR_SLOTS + 1),
  localparam int REG_W     = $clog2(REG_BLKS + 1),
  localparam int NGRP      = 1 << GID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [GID_W-1:0]  req_gid,
  input  logic [WCNT_W-1:0] req_warps,
  input  logic [SMEM_W-1:0] req_smem,
  input  logic [BAR_W-1:0]  req_bars,
  input  logic [REG_W-1:0]  req_regs,
  output logic              alloc_valid,
  output logic [SP_W-1:0]   alloc_sp,
  output logic [WID_W-1:0]  alloc_wid,
  output logic [GID_W-1:0]  alloc_gid,
  input  logic              retire_valid,
  input  logic [WID_W-1:0]  retire_wid,
  input  logic              drain_valid,
  input  logic [WID_W-1:0]  drain_wid,
  output logic              done_valid,
  output logic [GID_W-1:0]  done_gid
);
  localparam int NEED_W = WCNT_W + REG_W;

  cga_state_e        state_q;
  logic [WCNT_W-1:0] rem_q;
  logic [GID_W-1:0]  cur_gid_q;
  logic [REG_W-1:0]  cur_regs_q;
  logic [SP_W-1:0]   rr_q;

  logic [TOT_WARPS-1:0] busy_q, fin_q;
  logic [GID_W-1:0]     wgid_q  [TOT_WARPS];
  logic [REG_W-1:0]     wregs_q [TOT_WARPS];

  logic [WCNT_W-1:0] glive_q [NGRP];
  logic [SMEM_W-1:0] gsmem_q [NGRP];
  logic [BAR_W-1:0]  gbars_q [NGRP];

  logic [WCNT_W-1:0] free_w_q;
  logic [SMEM_W-1:0] free_s_q;
  logic [BAR_W-1:0]  free_b_q;
  logic [REG_W-1:0]  free_r_q;

  logic [NEED_W-1:0] reg_total;
  logic              fits;
  logic              pick_ok;
  logic [SP_W-1:0]   pick_sp;
  logic [WID_W-1:0]  pick_wid;

  // named events used by the update logic and the assertions
  logic             accept, alloc_fire, retire_ok, drain_ok, grp_last;
  logic [GID_W-1:0] drain_grp;

  cga_fit #(.WCNT_W(WCNT_W), .SMEM_W(SMEM_W), .BAR_W(BAR_W), .REG_W(REG_W)) u_fit (
    .need_warps(req_warps), .need_smem(req_smem), .need_bars(req_bars), .need_regs(req_regs),
    .free_warps(free_w_q),  .free_smem(free_s_q), .free_bars(free_b_q), .free_regs(free_r_q),
    .reg_total(reg_total),  .fits(fits)
  );

  cga_rr_pick #(.NUM_SP(NUM_SP), .SLOTS(SLOTS_PER_SP)) u_pick (
    .busy(busy_q), .ptr(rr_q), .pick_ok(pick_ok), .pick_sp(pick_sp), .pick_wid(pick_wid)
  );

  assign req_ready   = (state_q == ST_IDLE) && fits;
  assign accept      = req_valid && req_ready;
  assign alloc_valid = (state_q == ST_EMIT);
  assign alloc_fire  = alloc_valid && pick_ok;
  assign alloc_sp    = pick_sp;
  assign alloc_wid   = pick_wid;
  assign alloc_gid   = cur_gid_q;

  assign retire_ok = retire_valid && busy_q[retire_wid] && !fin_q[retire_wid];
  assign drain_ok  = drain_valid && busy_q[drain_wid] && fin_q[drain_wid];
  assign drain_grp = wgid_q[drain_wid];
  assign grp_last  = drain_ok && (glive_q[drain_grp] == WCNT_W'(1));

  // shared pools: admission takes, drain and group release give back
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_w_q <= WCNT_W'(TOT_WARPS);
      free_s_q <= SMEM_W'(SMEM_UNITS);
      free_b_q <= BAR_W'(BAR_SLOTS);
      free_r_q <= REG_W'(REG_BLKS);
    end else begin
      free_w_q <= free_w_q - (accept ? req_warps : '0) + (drain_ok ? WCNT_W'(1) : '0);
      free_r_q <= free_r_q - (accept ? REG_W'(reg_total) : '0)
                           + (drain_ok ? wregs_q[drain_wid] : '0);
      free_s_q <= free_s_q - (accept ? req_smem : '0) + (grp_last ? gsmem_q[drain_grp] : '0);
      free_b_q <= free_b_q - (accept ? req_bars : '0) + (grp_last ? gbars_q[drain_grp] : '0);
    end
  end

  // emission sequencer and rotating pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      cur_gid_q  <= '0;
      cur_regs_q <= '0;
      rr_q       <= '0;
    end else if (accept) begin
      state_q    <= ST_EMIT;
      rem_q      <= req_warps;
      cur_gid_q  <= req_gid;
      cur_regs_q <= req_regs;
    end else if (alloc_fire) begin
      rr_q  <= (pick_sp == SP_W'(NUM_SP - 1)) ? '0 : pick_sp + SP_W'(1);
      rem_q <= rem_q - WCNT_W'(1);
      if (rem_q == WCNT_W'(1)) state_q <= ST_IDLE;
    end
  end

  // per-warp binding table
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      fin_q  <= '0;
      for (int i = 0; i < TOT_WARPS; i++) begin
        wgid_q[i]  <= '0;
        wregs_q[i] <= '0;
      end
    end else begin
      if (drain_ok) begin
        busy_q[drain_wid] <= 1'b0;
        fin_q[drain_wid]  <= 1'b0;
      end
      if (retire_ok) fin_q[retire_wid] <= 1'b1;
      if (alloc_fire) begin
        busy_q[pick_wid]  <= 1'b1;
        wgid_q[pick_wid]  <= cur_gid_q;
        wregs_q[pick_wid] <= cur_regs_q;
      end
    end
  end

  // per-group table and completion pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_gid   <= '0;
      for (int g = 0; g < NGRP; g++) begin
        glive_q[g] <= '0;
        gsmem_q[g] <= '0;
        gbars_q[g] <= '0;
      end
    end else begin
      done_valid <= grp_last;
      if (grp_last) done_gid <= drain_grp;
      if (drain_ok) glive_q[drain_grp] <= glive_q[drain_grp] - WCNT_W'(1);
      if (accept) begin
        glive_q[req_gid] <= req_warps;
        gsmem_q[req_gid] <= req_smem;
        gbars_q[req_gid] <= req_bars;
      end
    end
  end

  assert_ready_low_in_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> !req_ready);

  assert_accept_starts_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> alloc_valid);

  assert_pick_free_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (pick_ok && !busy_q[alloc_wid]));

  assert_pick_on_pointer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !(&busy_q[int'(rr_q)*SLOTS_PER_SP +: SLOTS_PER_SP])) |-> (alloc_sp == rr_q));

  assert_done_follows_last_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(drain_ok));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (free_w_q <= WCNT_W'(TOT_WARPS)) && (free_r_q <= REG_W'(REG_BLKS))
    && (free_s_q <= SMEM_W'(SMEM_UNITS)) && (free_b_q <= BAR_W'(BAR_SLOTS)));

  assert_drain_needs_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !fin_q[drain_wid]) |=> $stable(free_w_q) || $past(accept));
endmodule

// File: tb/tb_cu_group_alloc.sv
module tb_cu_group_alloc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_gid = '0;
  logic [5:0] req_warps = '0;
  logic [8:0] req_smem = '0;
  logic [4:0] req_bars = '0;
  logic [8:0] req_regs = '0;
  logic       alloc_valid;
  logic [1:0] alloc_sp;
  logic [4:0] alloc_wid;
  logic [2:0] alloc_gid;
  logic       retire_valid = 1'b0;
  logic [4:0] retire_wid = '0;
  logic       drain_valid = 1'b0;
  logic [4:0] drain_wid = '0;
  logic       done_valid;
  logic [2:0] done_gid;

  always #4 clk = ~clk;  // 125 MHz

  cu_group_alloc dut (.*);

  int checks = 0;
  int failures = 0;

  // behavioural reference model
  int  m_busy[32], m_fin[32], m_wgid[32], m_wregs[32];
  int  m_live[8], m_smem[8], m_bars[8];
  int  m_fw, m_fs, m_fb, m_fr;
  int  m_emit, m_rem, m_gid, m_regs, m_rr;
  int  m_done, m_done_gid, m_accepted;

  task automatic m_reset();
    for (int i = 0; i < 32; i++) begin m_busy[i] = 0; m_fin[i] = 0; m_wgid[i] = 0; m_wregs[i] = 0; end
    for (int g = 0; g < 8; g++) begin m_live[g] = 0; m_smem[g] = 0; m_bars[g] = 0; end
    m_fw = 32; m_fs = 256; m_fb = 16; m_fr = 256;
    m_emit = 0; m_rem = 0; m_gid = 0; m_regs = 0; m_rr = 0;
    m_done = 0; m_done_gid = 0; m_accepted = 0;
  endtask

  function automatic int m_ready();
    int w;
    w = int'(req_warps);
    return (m_emit == 0) && (w >= 1) && (w <= m_fw) && (int'(req_smem) <= m_fs)
        && (int'(req_bars) <= m_fb) && (w * int'(req_regs) <= m_fr);
  endfunction

  task automatic m_pick(output int sp, output int wid);
    sp = -1; wid = -1;
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (m_rr + k) % 4;
      if (sp < 0) begin
        for (int s = 0; s < 8; s++)
          if (wid < 0 && m_busy[c*8 + s] == 0) begin sp = c; wid = c*8 + s; end
      end
    end
  endtask

  task automatic m_step();
    int acc, rok, dok, psp, pw, g;
    acc = m_ready() && req_valid;
    m_pick(psp, pw);
    rok = retire_valid && m_busy[retire_wid] && !m_fin[retire_wid];
    dok = drain_valid && m_busy[drain_wid] && m_fin[drain_wid];
    m_done = 0;
    if (dok) begin
      g = m_wgid[drain_wid];
      m_busy[drain_wid] = 0; m_fin[drain_wid] = 0;
      m_fw++; m_fr += m_wregs[drain_wid];
      m_live[g]--;
      if (m_live[g] == 0) begin
        m_fs += m_smem[g]; m_fb += m_bars[g];
        m_done = 1; m_done_gid = g;
      end
    end
    if (rok) m_fin[retire_wid] = 1;
    if (m_emit != 0) begin
      m_busy[pw] = 1; m_wgid[pw] = m_gid; m_wregs[pw] = m_regs;
      m_rr = (psp + 1) % 4;
      m_rem--;
      if (m_rem == 0) m_emit = 0;
    end
    if (acc) begin
      m_fw -= int'(req_warps); m_fs -= int'(req_smem); m_fb -= int'(req_bars);
      m_fr -= int'(req_warps) * int'(req_regs);
      g = int'(req_gid);
      m_live[g] = int'(req_warps); m_smem[g] = int'(req_smem); m_bars[g] = int'(req_bars);
      m_emit = 1; m_rem = int'(req_warps); m_gid = g; m_regs = int'(req_regs);
      m_accepted = 1;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int psp, pw;
    m_pick(psp, pw);
    chk("R1 R9 req_ready", int'(req_ready), m_ready());
    chk("R2 alloc_valid", int'(alloc_valid), m_emit != 0);
    if (m_emit != 0) begin
      chk("R3 alloc_sp", int'(alloc_sp), psp);
      chk("R4 alloc_wid", int'(alloc_wid), pw);
      chk("R2 alloc_gid", int'(alloc_gid), m_gid);
    end
    chk("R7 done_valid", int'(done_valid), m_done);
    if (m_done != 0) chk("R7 done_gid", int'(done_gid), m_done_gid);
  endtask

  // one cycle: inputs already set at the falling edge
  task automatic tick();
    #1 compare();
    @(posedge clk);
    m_step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_req(input int g, input int w, input int s, input int b, input int r);
    req_gid = 3'(g); req_warps = 6'(w); req_smem = 9'(s); req_bars = 5'(b); req_regs = 9'(r);
  endtask

  task automatic send(input int g, input int w, input int s, input int b, input int r);
    set_req(g, w, s, b, r);
    req_valid = 1'b1;
    m_accepted = 0;
    for (int i = 0; i < 200 && m_accepted == 0; i++) tick();
    req_valid = 1'b0;
    chk("R1 accepted", m_accepted, 1);
  endtask

  task automatic retire(input int w);
    retire_valid = 1'b1; retire_wid = 5'(w); tick(); retire_valid = 1'b0;
  endtask

  task automatic drain(input int w);
    drain_valid = 1'b1; drain_wid = 5'(w); tick(); drain_valid = 1'b0;
  endtask

  // retire then drain every warp of a group except `keep` of them
  task automatic free_group(input int g, input int keep);
    int left;
    left = 0;
    for (int w = 0; w < 32; w++) if (m_busy[w] != 0 && m_wgid[w] == g) left++;
    for (int w = 0; w < 32; w++)
      if (left > keep && m_busy[w] != 0 && m_wgid[w] == g) begin
        retire(w); drain(w); left--;
      end
  endtask

  function automatic int first_warp(input int g);
    for (int w = 0; w < 32; w++) if (m_busy[w] != 0 && m_wgid[w] == g) return w;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    #1;
    chk("R8 alloc_valid after reset", int'(alloc_valid), 0);
    chk("R8 done_valid after reset", int'(done_valid), 0);
    chk("R1 zero-warp request not ready", int'(req_ready), 0);
    set_req(0, 32, 256, 16, 8);
    #1 chk("R8 full pools fit a maximal request", int'(req_ready), 1);
    set_req(0, 0, 0, 0, 0);
    @(negedge clk);

    // R2 R3 R4: two groups, pointer carries over
    send(0, 3, 64, 2, 8);
    idle(4);
    send(1, 6, 32, 4, 4);
    idle(7);

    // R1: single-pool shortfalls, checked without valid
    set_req(2, 1, 0, 13, 1); idle(1);     // barriers 13 > 10 free
    set_req(2, 2, 0, 0, 200); idle(1);    // registers 400 > free
    set_req(2, 24, 0, 0, 0); idle(1);     // warps 24 > 23 free

    // R5: drain before retire has no effect, group not released
    w0 = first_warp(0);
    drain(w0); idle(2);
    // shared memory short: 200 > 160 free, held until group 0 leaves
    set_req(2, 4, 200, 2, 2);
    req_valid = 1'b1; m_accepted = 0;
    idle(3);
    chk("R1 request held on shared memory", m_accepted, 0);
    // R6 R7 R9: free group 0; final drain meets the waiting request
    free_group(0, 0);
    for (int i = 0; i < 10 && m_accepted == 0; i++) tick();
    req_valid = 1'b0;
    chk("R9 held request taken after release", m_accepted, 1);
    idle(5);

    // R3: fill most slots so the pointer must skip full sub-partitions
    send(3, 20, 8, 2, 1);
    idle(22);
    set_req(4, 3, 0, 0, 0); idle(1);      // only 2 free warps
    // drain while a new group is placed (same-cycle slot free and take)
    send(4, 2, 0, 1, 1);
    w0 = first_warp(1);
    retire(w0);
    drain_valid = 1'b1; drain_wid = 5'(w0); tick(); drain_valid = 1'b0;
    idle(3);
    // R6: returned slot is reusable
    send(5, 1, 0, 0, 3);
    idle(3);

    // drain everything, each group pulses done once
    for (int g = 0; g < 8; g++) free_group(g, 0);
    idle(3);
    set_req(0, 32, 256, 16, 8);
    #1 chk("R6 R7 all pools returned", int'(req_ready), 1);
    set_req(0, 0, 0, 0, 0);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule